// File: doc/BRIEF.md
# Flash Program Status Controller

This block keeps the status byte that a serial flash host reads while a program operation runs. It holds three live bits: a busy flag, a write-enable latch and a sticky program-error flag. The host first issues a write-enable command, which arms the latch. It then sends a program request. That request is honoured only while the latch is armed and no operation is running. An accepted request starts an internal program cycle that lasts a fixed number of clock cycles, and busy stays high for all of it.

Partway through the cycle the write-enable latch drops by itself. A per-byte verify strobe from the array side may fire during the cycle. If it fires in any busy cycle, the error flag is raised when the cycle ends, and it stays set until the next accepted program request. The status byte comes straight from the held state, so the host can read it at any moment and poll busy instead of waiting out the worst-case program time.

Top module: `flashStatusCtl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the status byte reads 0x00. This holds even when reset interrupts a running program cycle.
- R2: A write-enable command in an idle cycle sets status bit 1 (WEL) at the next clock edge.
- R3: A program request is accepted only when bit 0 (busy) is 0 and WEL is 1. Any other request changes no status bit, and a request made during a running cycle neither restarts it nor extends it.
- R4: After an accepted request, status bit 0 reads 1 for exactly PROG_CYCLES cycles, starting at the clock edge that accepts the request, and then returns to 0.
- R5: WEL is cleared at clock edge WEL_CLR_AT+1 after acceptance, which is before busy falls.
- R6: Status bit 5 (EPE) is cleared at the edge that accepts a request. At the edge where busy falls it is set if the verify-fail input was high in any busy cycle, the final one included.
- R7: Outside the accept and finish edges, EPE holds its value. A verify-fail pulse while idle has no effect on it.
- R8: A write-enable command while busy is ignored, so WEL stays 0 after its automatic clear.
- R9: Status bits 2, 3, 4, 6 and 7 always read 0, and the status byte is valid in every cycle, busy ones included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEnCmd | input | 1 | Write-enable command strobe |
| progReq | input | 1 | Program request strobe |
| byteFail | input | 1 | Per-byte verify failure strobe from the array side |
| statusOut | output | 8 | Status byte: bit 0 busy, bit 1 WEL, bit 5 EPE |

## Verification
The assertions check on every cycle that a request is refused while WEL is 0, that the cycle counter stays in range and busy always falls after the last count, that WEL is already clear when the finish strobe fires, and that EPE moves only on the start and finish strobes. Only the bench scenarios can show the exact cycle counts of busy and the WEL clear, that errors are captured in the first and last busy cycles, that requests and write-enables arriving mid-cycle leave the operation undisturbed, and that the error bit stays set across a refused request.

// File: rtl/flashStatusPkg.sv
package flashStatusPkg;
  localparam int STATUS_W = 8;
  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL  = 1;
  localparam int BIT_EPE  = 5;

  typedef struct packed {
    logic welSet;    // arm write-enable latch
    logic startOp;   // program request accepted
    logic welClr;    // automatic latch clear point reached
    logic failMark;  // verify failure seen in a busy cycle
    logic finishOp;  // last cycle of the program operation
  } strobe_t;
endpackage

// File: rtl/flashStatusCtrl.sv
module flashStatusCtrl
  import flashStatusPkg::*;
#(
  parameter int PROG_CYCLES = 40,
  parameter int WEL_CLR_AT  = 20
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEnCmd,
  input  logic    progReq,
  input  logic    byteFail,
  input  logic    welIn,
  output logic    busyOut,
  output strobe_t strb
);
  localparam int CNT_W = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 2;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] CLR_CNT  = CNT_W'(WEL_CLR_AT);

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             atLast;

  assign atLast = busyQ && (cntQ == LAST_CNT);

  always_comb begin
    strb          = '0;
    strb.welSet   = wrEnCmd && !busyQ;
    strb.startOp  = progReq && !busyQ && welIn;
    strb.welClr   = busyQ && (cntQ == CLR_CNT);
    strb.failMark = busyQ && byteFail;
    strb.finishOp = atLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (strb.startOp) begin
      busyQ <= 1'b1;
      cntQ  <= '0;
    end else if (atLast) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (busyQ) begin
      cntQ  <= cntQ + 1'b1;
    end
  end

  assign busyOut = busyQ;

  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && progReq && !welIn) |=> !busyQ); // R3
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (cntQ <= LAST_CNT)); // R4
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    atLast |=> !busyQ); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !atLast) |=> (busyQ && cntQ == $past(cntQ) + 1'b1)); // R3
endmodule

// File: rtl/flashStatusRegs.sv
module flashStatusRegs
  import flashStatusPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic                busyIn,
  output logic                welOut,
  output logic [STATUS_W-1:0] statusOut
);
  logic welQ;
  logic epeQ;
  logic failAccQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      welQ     <= 1'b0;
      epeQ     <= 1'b0;
      failAccQ <= 1'b0;
    end else begin
      if (strb.welClr)      welQ <= 1'b0;
      else if (strb.welSet) welQ <= 1'b1;

      if (strb.startOp)       failAccQ <= 1'b0;
      else if (strb.failMark) failAccQ <= 1'b1;

      if (strb.startOp)       epeQ <= 1'b0;
      else if (strb.finishOp) epeQ <= failAccQ | strb.failMark;
    end
  end

  always_comb begin
    statusOut           = '0;
    statusOut[BIT_BUSY] = busyIn;
    statusOut[BIT_WEL]  = welQ;
    statusOut[BIT_EPE]  = epeQ;
  end

  assign welOut = welQ;

  AST_WEL_GONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    strb.finishOp |-> !welQ); // R5
  AST_EPE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.startOp && !strb.finishOp) |=> $stable(epeQ)); // R7
  AST_EPE_CLEARED_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    strb.startOp |=> !epeQ); // R6
  AST_WEL_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && !strb.welClr) |=> $stable(welQ)); // R8
endmodule

// File: rtl/flashStatusCtl.sv
module flashStatusCtl
  import flashStatusPkg::*;
#(
  parameter int PROG_CYCLES = 40,
  parameter int WEL_CLR_AT  = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEnCmd,
  input  logic       progReq,
  input  logic       byteFail,
  output logic [7:0] statusOut
);
  strobe_t strb;
  logic    busy;
  logic    wel;

  flashStatusCtrl #(
    .PROG_CYCLES(PROG_CYCLES),
    .WEL_CLR_AT (WEL_CLR_AT)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEnCmd (wrEnCmd),
    .progReq (progReq),
    .byteFail(byteFail),
    .welIn   (wel),
    .busyOut (busy),
    .strb    (strb)
  );

  flashStatusRegs regs_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busyIn   (busy),
    .welOut   (wel),
    .statusOut(statusOut)
  );

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut & 8'hDC) == 8'h00); // R9
endmodule

// File: tb/flashStatusCtl_tb.sv
module flashStatusCtl_tb_top;
  localparam int PROG = 12;
  localparam int WCLR = 5;

  typedef struct packed {
    int wen;     // issue write-enable first
    int failAt;  // busy cycle with a verify failure, 0 = none
    int reqAt;   // busy cycle with an extra request, 0 = none
    int wenAt;   // busy cycle with an extra write-enable, 0 = none
    int expEpe;  // expected EPE after the operation
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1, 0,    0, 0,        0},
    '{1, 3,    0, 0,        1},
    '{0, 0,    0, 0,        1},
    '{1, 0,    2, 0,        0},
    '{1, PROG, 0, WCLR + 4, 1},
    '{1, 1,    0, 0,        1},
    '{1, 0,    0, 0,        0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEnCmd = 1'b0;
  logic       progReq = 1'b0;
  logic       byteFail = 1'b0;
  logic [7:0] statusOut;

  int nTests = 0;
  int nFail = 0;
  logic expBusy = 1'b0, expWel = 1'b0, expEpe = 1'b0;

  always #2 clk = ~clk;

  flashStatusCtl #(.PROG_CYCLES(PROG), .WEL_CLR_AT(WCLR)) dut_i (
    .clk(clk), .rstN(rstN), .wrEnCmd(wrEnCmd), .progReq(progReq),
    .byteFail(byteFail), .statusOut(statusOut)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkStatus(input string tag);
    logic [7:0] exp;
    exp = {2'b00, expEpe, 3'b000, expWel, expBusy};
    nTests++;
    if (statusOut !== exp) begin
      nFail++;
      $display("FAIL %s: status got %02h expected %02h", tag, statusOut, exp);
    end
  endtask

  task automatic runProg(input vec_t v, input string tag);
    logic acc;
    logic accept;
    if (v.wen != 0) begin
      wrEnCmd = 1'b1; step(); wrEnCmd = 1'b0;
      expWel = 1'b1;
      checkStatus({tag, " R2 wel set"});
    end
    accept = expWel && !expBusy;
    progReq = 1'b1; step(); progReq = 1'b0;
    if (!accept) begin
      checkStatus({tag, " R3 refused"});
    end else begin
      expBusy = 1'b1; expEpe = 1'b0;
      checkStatus({tag, " R4 R6 accept"});
      acc = 1'b0;
      for (int k = 1; k <= PROG; k++) begin
        byteFail = (k == v.failAt);
        progReq  = (k == v.reqAt);
        wrEnCmd  = (k == v.wenAt);
        step();
        byteFail = 1'b0; progReq = 1'b0; wrEnCmd = 1'b0;
        if (k == v.failAt) acc = 1'b1;
        if (k == WCLR + 1) expWel = 1'b0;
        if (k == PROG) begin expBusy = 1'b0; expEpe = acc; end
        if (k == WCLR + 1)      checkStatus({tag, " R5 wel auto clear"});
        else if (k == PROG)     checkStatus({tag, " R4 R6 finish"});
        else if (k > WCLR + 1)  checkStatus({tag, " R8 R3 busy"});
        else                    checkStatus({tag, " R4 R9 busy"});
      end
    end
    nTests++;
    if (statusOut[5] !== v.expEpe[0]) begin
      nFail++;
      $display("FAIL %s R6 R7: epe got %0b expected %0b", tag, statusOut[5], v.expEpe[0]);
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nTests++; nFail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", nTests, nFail);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    step();
    checkStatus("R1 in reset");
    rstN = 1'b1;
    checkStatus("R1 after release");

    for (int i = 0; i < NVEC; i++) begin
      runProg(VECS[i], $sformatf("vec%0d", i));
    end

    // R7: verify failure while idle is ignored
    byteFail = 1'b1; step(); byteFail = 1'b0;
    checkStatus("R7 idle fail ignored");
    expWel = 1'b1; wrEnCmd = 1'b1; step(); wrEnCmd = 1'b0;
    checkStatus("R2 arm again");
    byteFail = 1'b1; step(); byteFail = 1'b0;
    checkStatus("R7 idle fail with wel");

    // R3: request with WEL clear in idle after a failed op keeps EPE
    runProg('{1, 2, 0, 0, 1}, "seqA");
    runProg('{0, 0, 0, 0, 1}, "seqB R3");

    // R1: reset during a running cycle
    wrEnCmd = 1'b1; step(); wrEnCmd = 1'b0; expWel = 1'b1;
    progReq = 1'b1; step(); progReq = 1'b0; expBusy = 1'b1; expEpe = 1'b0;
    checkStatus("R4 start before reset");
    step(); step();
    rstN = 1'b0; step();
    expBusy = 1'b0; expWel = 1'b0; expEpe = 1'b0;
    checkStatus("R1 reset mid cycle");
    rstN = 1'b1; step();
    checkStatus("R1 idle after reset");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule